// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a write to a serial EEPROM, the memory ignores the bus until its internal programming cycle has ended. This sequencer sits on the master side of an I2C bus and finds out when that cycle is over. It repeatedly opens the bus and offers the device-select byte in the write direction. A missing acknowledge means the device is still busy, so the sequencer waits a programmable number of idle cycles and tries again. The first acknowledged select is not thrown away: it becomes the opening byte of the next command.

A request carries the kind of the next operation and a byte address. When the device answers, the sequencer does one of three things. It closes the bus with STOP if the next operation does not touch the memory. For a write, it sends the byte address and hands the open bus to the caller for the data bytes. For a random read, it sends the byte address, issues a repeated START and a read-direction select, then hands the bus over for data reception. Bit-level signalling is left to a byte engine beneath it: the sequencer issues one bus operation at a time and waits for the engine's completion and acknowledge report. The number of attempts has a programmable limit; running out of attempts ends the transfer with STOP and an error.

Top module: `ackpoll_seq`

## Requirements
- R1: Each poll attempt issues a START operation (op code 0) and then a SEND (op code 3) of the byte {devId, 0}, with the direction bit in bit 0 cleared.
- R2: When a write-direction select is not acknowledged and attempts remain, the next START is issued exactly gapCycles+2 clock cycles after the cycle in which engDone reported the rejection.
- R3: When the select is acknowledged and reqKind is 0 (no memory access; code 3 acts the same), the sequencer issues STOP (op code 2) and then pulses done with error low.
- R4: When the select is acknowledged and reqKind is 1 (write), the next operation is a SEND of reqAddr, with no new START or select. An acknowledged address pulses handoffWrite together with done, and no STOP is issued.
- R5: For reqKind 2 (random read), an acknowledged address is followed by RESTART (op code 1) and a SEND of {devId, 1}. When that select is acknowledged, handoffRead pulses together with done.
- R6: At most max(maxPolls,1) write-direction selects are issued per request. When the last one is rejected, STOP is issued and done pulses with error high. error only ever rises together with done.
- R7: A rejected byte address, or a rejected read-direction select, ends the request with STOP and done with error high.
- R8: busy is high from the cycle after a request is accepted until completion. done is a one-cycle pulse in the first cycle with busy low. error stays valid from done until the next request is accepted, which clears it.
- R9: reqValid is ignored while busy. The latched kind and address are not changed, and no extra operations are issued.
- R10: After reset, busy, done, error, engGo and both handoff outputs are low. engGo is a one-cycle strobe, and no new operation is issued before engDone has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, accepted when idle |
| reqKind | input | 2 | Next operation: 0 none, 1 write, 2 random read |
| reqAddr | input | BYTE_W | Byte address for the next operation |
| devId | input | BYTE_W-1 | Device address placed above the direction bit |
| maxPolls | input | LIMIT_W | Attempt limit (0 acts as 1) |
| gapCycles | input | GAP_W | Idle cycles inserted between attempts |
| engGo | output | 1 | One-cycle strobe that starts a byte-engine operation |
| engOp | output | 2 | Operation: 0 START, 1 RESTART, 2 STOP, 3 SEND |
| engByte | output | BYTE_W | Byte to send for SEND |
| engDone | input | 1 | Engine finished the current operation |
| engAck | input | 1 | Acknowledge seen for a SEND, valid with engDone |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request ended in failure |
| handoffWrite | output | 1 | Bus left open after the address, ready for write data |
| handoffRead | output | 1 | Bus left open after the read select, ready for read data |

## Verification
The bench targets the off-by-one spots. These are the idle gap between attempts, the attempt limit when success comes on the very last allowed try, and a limit of zero. A design that miscounts would either retry once too often, shown as an extra START in the scoreboard, or give up one attempt early with a false error. It also checks that an acknowledged select is reused: a design that re-opens the bus before the address would show an unexpected START. It drives a stray request during a busy sequence; a design that latched it would change the address or branch. Rejected addresses and rejected read selects are checked to end in STOP with error, not in a handoff.

// File: rtl/ackpoll_pkg.sv
`timescale 1ns/1ps
package ackpoll_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_SEND    = 2'd3
  } busOp_e;

  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_READ  = 2'd2;

  typedef enum logic [1:0] {
    SEL_DEV_WR = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_DEV_RD = 2'd2
  } byteSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DSEL, ST_GAP, ST_ADDR, ST_RSTART, ST_RSEL, ST_STOP
  } pollState_e;

  typedef struct packed {
    logic     loadCmd;
    logic     incTry;
    logic     loadGap;
    logic     decGap;
    byteSel_e byteSel;
  } dpStrobe_t;

endpackage

// File: rtl/ackpoll_dp.sv
`timescale 1ns/1ps
module ackpoll_dp
  import ackpoll_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LIMIT_W = 8,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [1:0]         reqKind,
  input  logic [BYTE_W-1:0]  reqAddr,
  input  logic [BYTE_W-2:0]  devId,
  input  logic [LIMIT_W-1:0] maxPolls,
  input  logic [GAP_W-1:0]   gapCycles,
  output logic [BYTE_W-1:0]  engByte,
  output logic               kindWrite,
  output logic               kindRead,
  output logic               lastTry,
  output logic               gapZero
);
  localparam int CNT_W = LIMIT_W + 1;

  logic [1:0]         kindQ;
  logic [BYTE_W-1:0]  addrQ;
  logic [BYTE_W-2:0]  devQ;
  logic [LIMIT_W-1:0] tryCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic [LIMIT_W-1:0] maxEff;
  logic [CNT_W-1:0]   tryNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= KIND_NONE;
      addrQ <= '0;
      devQ  <= '0;
    end else if (strobe.loadCmd) begin
      kindQ <= reqKind;
      addrQ <= reqAddr;
      devQ  <= devId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tryCnt <= '0;
    else if (strobe.loadCmd)  tryCnt <= '0;
    else if (strobe.incTry)   tryCnt <= tryCnt + LIMIT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= '0;
    else if (strobe.loadGap) gapCnt <= gapCycles;
    else if (strobe.decGap)  gapCnt <= gapCnt - GAP_W'(1);
  end

  assign maxEff    = (maxPolls == '0) ? LIMIT_W'(1) : maxPolls;
  assign tryNext   = {1'b0, tryCnt} + CNT_W'(1);
  assign lastTry   = tryNext >= {1'b0, maxEff};
  assign gapZero   = (gapCnt == '0);
  assign kindWrite = (kindQ == KIND_WRITE);
  assign kindRead  = (kindQ == KIND_READ);

  always_comb begin
    case (strobe.byteSel)
      SEL_ADDR:   engByte = addrQ;
      SEL_DEV_RD: engByte = {devQ, 1'b1};
      default:    engByte = {devQ, 1'b0};
    endcase
  end

  // R6: a counted attempt is always within the allowed number
  a_r6_try_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incTry |-> ({1'b0, tryCnt} < {1'b0, maxEff}));

  // R2: the idle gap counts down one per cycle
  a_r2_gap_down: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decGap |=> (gapCnt == $past(gapCnt) - GAP_W'(1)));

endmodule

// File: rtl/ackpoll_ctrl.sv
`timescale 1ns/1ps
module ackpoll_ctrl
  import ackpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      engDone,
  input  logic      engAck,
  input  logic      kindWrite,
  input  logic      kindRead,
  input  logic      lastTry,
  input  logic      gapZero,
  output dpStrobe_t strobe,
  output logic      engGo,
  output busOp_e    engOp,
  output logic      busy,
  output logic      done,
  output logic      error,
  output logic      handoffWrite,
  output logic      handoffRead
);
  pollState_e state, stateNxt;
  logic pend;
  logic errPend, errPendNxt;
  logic doneNxt, hoWNxt, hoRNxt;
  logic issuing, finish;

  assign issuing = (state == ST_START) || (state == ST_DSEL) || (state == ST_ADDR) ||
                   (state == ST_RSTART) || (state == ST_RSEL) || (state == ST_STOP);
  assign engGo  = issuing && !pend;
  assign finish = pend && engDone;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stateNxt   = state;
    errPendNxt = errPend;
    doneNxt    = 1'b0;
    hoWNxt     = 1'b0;
    hoRNxt     = 1'b0;
    strobe     = '{loadCmd: 1'b0, incTry: 1'b0, loadGap: 1'b0, decGap: 1'b0,
                   byteSel: SEL_DEV_WR};
    engOp      = OP_START;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadCmd = 1'b1;
          errPendNxt     = 1'b0;
          stateNxt       = ST_START;
        end
      end
      ST_START: begin
        engOp = OP_START;
        if (finish) stateNxt = ST_DSEL;
      end
      ST_DSEL: begin
        engOp          = OP_SEND;
        strobe.byteSel = SEL_DEV_WR;
        if (finish) begin
          strobe.incTry = 1'b1;
          if (engAck) begin
            stateNxt = (kindWrite || kindRead) ? ST_ADDR : ST_STOP;
          end else if (lastTry) begin
            errPendNxt = 1'b1;
            stateNxt   = ST_STOP;
          end else begin
            strobe.loadGap = 1'b1;
            stateNxt       = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gapZero) stateNxt = ST_START;
        else         strobe.decGap = 1'b1;
      end
      ST_ADDR: begin
        engOp          = OP_SEND;
        strobe.byteSel = SEL_ADDR;
        if (finish) begin
          if (!engAck) begin
            errPendNxt = 1'b1;
            stateNxt   = ST_STOP;
          end else if (kindWrite) begin
            doneNxt  = 1'b1;
            hoWNxt   = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            stateNxt = ST_RSTART;
          end
        end
      end
      ST_RSTART: begin
        engOp = OP_RESTART;
        if (finish) stateNxt = ST_RSEL;
      end
      ST_RSEL: begin
        engOp          = OP_SEND;
        strobe.byteSel = SEL_DEV_RD;
        if (finish) begin
          if (engAck) begin
            doneNxt  = 1'b1;
            hoRNxt   = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            errPendNxt = 1'b1;
            stateNxt   = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        engOp = OP_STOP;
        if (finish) begin
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      pend         <= 1'b0;
      errPend      <= 1'b0;
      done         <= 1'b0;
      handoffWrite <= 1'b0;
      handoffRead  <= 1'b0;
      error        <= 1'b0;
    end else begin
      state        <= stateNxt;
      errPend      <= errPendNxt;
      done         <= doneNxt;
      handoffWrite <= hoWNxt;
      handoffRead  <= hoRNxt;
      if (engGo)        pend <= 1'b1;
      else if (engDone) pend <= 1'b0;
      if (strobe.loadCmd) error <= 1'b0;
      else if (doneNxt)   error <= errPendNxt;
    end
  end

  // R10: a new operation only after the previous one was answered
  a_r10_single_go: assert property (@(posedge clk) disable iff (!rstN)
    engGo |=> !engGo);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done shows in the first idle cycle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: handoffs coincide with done
  a_r8_handoff_done: assert property (@(posedge clk) disable iff (!rstN)
    (handoffWrite || handoffRead) |-> done);

  // R6: error can only rise at completion
  a_r6_err_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

endmodule

// File: rtl/ackpoll_seq.sv
`timescale 1ns/1ps
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LIMIT_W = 8,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [BYTE_W-1:0]  reqAddr,
  input  logic [BYTE_W-2:0]  devId,
  input  logic [LIMIT_W-1:0] maxPolls,
  input  logic [GAP_W-1:0]   gapCycles,
  output logic               engGo,
  output logic [1:0]         engOp,
  output logic [BYTE_W-1:0]  engByte,
  input  logic               engDone,
  input  logic               engAck,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               handoffWrite,
  output logic               handoffRead
);
  dpStrobe_t strobe;
  busOp_e    opEnum;
  logic      kindWrite, kindRead, lastTry, gapZero;

  ackpoll_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .engDone(engDone), .engAck(engAck),
    .kindWrite(kindWrite), .kindRead(kindRead),
    .lastTry(lastTry), .gapZero(gapZero),
    .strobe(strobe), .engGo(engGo), .engOp(opEnum),
    .busy(busy), .done(done), .error(error),
    .handoffWrite(handoffWrite), .handoffRead(handoffRead)
  );

  ackpoll_dp #(.BYTE_W(BYTE_W), .LIMIT_W(LIMIT_W), .GAP_W(GAP_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqKind(reqKind), .reqAddr(reqAddr), .devId(devId),
    .maxPolls(maxPolls), .gapCycles(gapCycles),
    .engByte(engByte), .kindWrite(kindWrite), .kindRead(kindRead),
    .lastTry(lastTry), .gapZero(gapZero)
  );

  assign engOp = opEnum;

  // R1: every bus operation happens inside a busy window
  a_r1_go_busy: assert property (@(posedge clk) disable iff (!rstN)
    engGo |-> busy);

endmodule

// File: tb/ackpoll_seq_test.sv
`timescale 1ns/1ps
module ackpoll_seq_test;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [1:0] OPS = 2'd0, OPR = 2'd1, OPP = 2'd2, OPD = 2'd3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [7:0] reqAddr = 8'h00;
  logic [7:0] maxPolls = 8'd4, gapCycles = 8'd0;
  logic engGo, engDone = 1'b0, engAck = 1'b0;
  logic [1:0] engOp;
  logic [7:0] engByte;
  logic busy, done, error, handoffWrite, handoffRead;

  int checks = 0, errors = 0, cyc = 0;
  logic [9:0] expQ[$];
  string tagQ[$];
  int nackLeft = 0, respCnt = 0, lastNackCyc = 0, curGap = 0;
  bit addrOkCfg = 1, rselOkCfg = 1, pendAck = 0, pendSelNack = 0, gapArm = 0;

  ackpoll_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .devId(DEV), .maxPolls(maxPolls), .gapCycles(gapCycles),
    .engGo(engGo), .engOp(engOp), .engByte(engByte), .engDone(engDone),
    .engAck(engAck), .busy(busy), .done(done), .error(error),
    .handoffWrite(handoffWrite), .handoffRead(handoffRead)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input string tag);
    expQ.push_back({op, b});
    tagQ.push_back(tag);
  endtask

  // engine model plus scoreboard monitor
  always @(negedge clk) begin
    engDone = 1'b0;
    if (respCnt > 0) begin
      respCnt--;
      if (respCnt == 0) begin
        engDone = 1'b1;
        engAck  = pendAck;
        if (pendSelNack) begin lastNackCyc = cyc; gapArm = 1; end
      end
    end
    if (rstN && engGo) begin
      logic [9:0] e;
      string t;
      check("R8", "busy during operation", int'(busy), 1);
      if (expQ.size() == 0) begin
        check("R9", "unexpected operation", int'({engOp, engByte}), 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, "operation code", int'(engOp), int'(e[9:8]));
        if (e[9:8] == OPD) check(t, "sent byte", int'(engByte), int'(e[7:0]));
      end
      if (gapArm && engOp == OPS)
        check("R2", "retry spacing", cyc - lastNackCyc, curGap + 2);
      gapArm = 0;
      pendSelNack = 0;
      pendAck = 1;
      if (engOp == OPD) begin
        if (engByte == {DEV, 1'b0}) begin
          pendAck = (nackLeft == 0);
          if (nackLeft > 0) begin nackLeft--; pendSelNack = 1; end
        end else if (engByte == {DEV, 1'b1}) pendAck = rselOkCfg;
        else pendAck = addrOkCfg;
      end
      respCnt = 2;
    end
  end

  task automatic runCase(input int kind, input logic [7:0] addr, input int nacks,
                         input bit addrOk, input bit rselOk, input int limit,
                         input int gap, input bit poke);
    int maxEff, tries;
    bit expErr, expHw, expHr, gotDone;
    maxEff = (limit == 0) ? 1 : limit;
    maxPolls = 8'(limit); gapCycles = 8'(gap); curGap = gap;
    nackLeft = nacks; addrOkCfg = addrOk; rselOkCfg = rselOk;
    expErr = 0; expHw = 0; expHr = 0;
    tries = (nacks + 1 > maxEff) ? maxEff : nacks + 1;
    for (int i = 0; i < tries; i++) begin
      push(OPS, 8'h00, (i == 0) ? "R1" : "R2");
      push(OPD, {DEV, 1'b0}, (i == 0) ? "R1" : "R2");
    end
    if (nacks >= maxEff) begin
      push(OPP, 8'h00, "R6"); expErr = 1;
    end else if (kind == 1 || kind == 2) begin
      push(OPD, addr, kind == 1 ? "R4" : "R5");
      if (!addrOk) begin push(OPP, 8'h00, "R7"); expErr = 1; end
      else if (kind == 1) expHw = 1;
      else begin
        push(OPR, 8'h00, "R5");
        push(OPD, {DEV, 1'b1}, "R5");
        if (rselOk) expHr = 1;
        else begin push(OPP, 8'h00, "R7"); expErr = 1; end
      end
    end else begin
      push(OPP, 8'h00, "R3");
    end
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'(kind); reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check("R8", "busy after accept", int'(busy), 1);
    check("R8", "error cleared on accept", int'(error), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      reqValid = 1'b1; reqKind = 2'd2; reqAddr = 8'h33;
      @(negedge clk);
      reqValid = 1'b0; reqKind = 2'(kind); reqAddr = addr;
    end
    gotDone = 0;
    for (int k = 0; k < 5000 && !gotDone; k++) begin
      if (done) gotDone = 1; else @(negedge clk);
    end
    check("R8", "done seen", int'(gotDone), 1);
    check("R8", "busy low at done", int'(busy), 0);
    check(expErr ? "R6" : "R3", "error at done", int'(error), int'(expErr));
    check("R4", "handoffWrite", int'(handoffWrite), int'(expHw));
    check("R5", "handoffRead", int'(handoffRead), int'(expHr));
    @(negedge clk);
    check("R8", "done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    check("R8", "error held", int'(error), int'(expErr));
    check("R9", "queue drained", expQ.size(), 0);
    expQ.delete(); tagQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset busy", int'(busy), 0);
    check("R10", "reset done", int'(done), 0);
    check("R10", "reset error", int'(error), 0);
    check("R10", "reset engGo", int'(engGo), 0);
    check("R10", "reset handoffs", int'({handoffWrite, handoffRead}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runCase(1, 8'h12, 0, 1, 1, 5, 3, 0);   // R4 immediate ack
    runCase(1, 8'h7e, 3, 1, 1, 8, 4, 1);   // R2 retries, R9 stray request
    runCase(2, 8'h40, 2, 1, 1, 4, 0, 0);   // R5 read, zero gap
    runCase(0, 8'h00, 1, 1, 1, 4, 2, 0);   // R3 no memory access
    runCase(1, 8'h21, 10, 1, 1, 3, 1, 0);  // R6 limit exceeded
    runCase(2, 8'h22, 1, 1, 1, 0, 0, 0);   // R6 limit zero acts as one
    runCase(1, 8'h55, 0, 0, 1, 4, 0, 0);   // R7 address rejected
    runCase(2, 8'h66, 0, 1, 0, 4, 0, 0);   // R7 read select rejected
    runCase(2, 8'h08, 2, 1, 1, 3, 5, 0);   // R6 success on last try
    runCase(3, 8'h09, 0, 1, 1, 2, 0, 0);   // R3 code 3, error cleared
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: timeout actual=%0d expected=%0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule